// File: doc/BRIEF.md
# Address-Masked GPIO Register Port

This block is the register side of an eight-pin general-purpose I/O controller. It occupies a 4 KB window. The lowest kilobyte is one data register that repeats at 256 word addresses. Address bits 9:2 of each access act as a per-bit mask, so software can read or change any subset of pins in one access, with no read-modify-write sequence. Above that window sit a direction register, storage registers for interrupt configuration, an alternate-function select, and a bank of pad-control registers. A lock state machine guards a commit register, and an analog-select register and a read-only identification area complete the map.

A parameter picks one of two variants. The base variant stops after the alternate-function register. The extended variant adds the pad-control bank, the lock/commit pair and the analog-select register. The two variants also differ in where the reserved region begins and in their identification bytes. Each access is one request cycle. The response (valid, read data and a one-cycle error flag) follows on the next cycle.

The lock guard is a two-state machine. `LK_SHUT` is the reset state. The transition `UNLOCK` (a write of the key word to the lock offset) moves it to `LK_OPEN`. The transition `RELOCK` (a write of any other value to the lock offset) moves it back to `LK_SHUT`. All other accesses keep the current state.

Top module: `gpio_maskport`

## Requirements
- R1: After reset, every register reads zero except the 2 mA drive register (0x500) and the commit register (0x524), which read 0xFF, and the lock register (0x520), which reads 1. `pin_out` and `pin_oe` are both 0.
- R2: A read at an offset below 0x400 returns the data register ANDed with address bits 9:2 in `rsp_rdata[7:0]`, with the upper bits zero and no error.
- R3: A write at an offset below 0x400 changes only the data bits whose address bit (9:2) is 1. The other bits keep their value. `pin_out` always shows the data register.
- R4: Register writes keep only `acc_wdata[7:0]`. The direction register at 0x400 drives `pin_oe`, and only a write to 0x400 changes `pin_oe`.
- R5: `rsp_valid` is high exactly one cycle after each cycle with `acc_valid` high. `rsp_err` is high only together with `rsp_valid`, for that single cycle.
- R6: Reads at 0xFD0..0xFFC return the byte at index (offset-0xFD0)>>2 of the variant's ID table. Extended: 00,00,00,00,47,15,08,00,0D,F0,05,B1. Base: 00,00,00,00,46,15,18,00,0D,F0,05,B1.
- R7: The reserved region starts at 0x424 in the base variant (EXTENDED=0) and at 0x52C in the extended variant. A read from the start up to 0xFCC inclusive returns 0 with `rsp_err`=1.
- R8: A write at or above the reserved start, including the ID area, has no effect and sets `rsp_err`.
- R9: An access below the reserved start and at or above 0x400 that hits no listed register, or whose address bits 1:0 are non-zero, reads 0 with `rsp_err`=1. If it is a write, it has no effect.
- R10: The lock register (0x520, extended) reads 0 after the key `UNLOCK_KEY` (default 0xC0DE5A1E, full 32 bits) is written to it. It reads 1 again after any other value is written to it.
- R11: A write to the commit register (0x524) takes effect only while unlocked. A write while locked is ignored without error. In the base variant the commit value is fixed at 0xFF.
- R12: A write to the alternate-function register (0x420) updates only the bits set in the commit register.
- R13: The sense (0x404), both-edges (0x408), event (0x40C) and mask (0x410) registers read back what was written. Raw status (0x414) and masked status (0x418) read 0. The clear register (0x41C) accepts writes without error and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset within the window |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| rsp_err | output | 1 | One-cycle error flag with the response |
| pin_out | output | 8 | Data register value driven to the pins |
| pin_oe | output | 8 | Direction register (1 = output) |

## Verification
Every response, read data and error flag included, is due one clock edge after the edge that samples the request. A register update takes effect at that same edge, so the next access already sees the new value. The lock state changes at the edge of the lock write, so a commit write in the following cycle is judged against the new state. The bench drives each request on the falling edge and samples the response 2 ns after the next rising edge. It checks `pin_out`/`pin_oe` at that same point. It also confirms that both `rsp_valid` and `rsp_err` are low one edge later. Both variants are instantiated on the same bus, so each offset is checked against both reserved-region boundaries at once.

// File: rtl/gpm_pkg.sv
package gpm_pkg;

    typedef enum logic [3:0] {
        SEL_DATA,
        SEL_DIR,
        SEL_ISENSE,
        SEL_IBOTH,
        SEL_IEVENT,
        SEL_IMASK,
        SEL_RDZERO,
        SEL_AFSEL,
        SEL_PAD,
        SEL_LOCK,
        SEL_COMMIT,
        SEL_ANALOG,
        SEL_ID,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic {
        LK_SHUT,
        LK_OPEN
    } lock_st_e;

    // word offsets (byte offset >> 2)
    localparam logic [9:0] W_DIR     = 10'h100;
    localparam logic [9:0] W_ISENSE  = 10'h101;
    localparam logic [9:0] W_IBOTH   = 10'h102;
    localparam logic [9:0] W_IEVENT  = 10'h103;
    localparam logic [9:0] W_IMASK   = 10'h104;
    localparam logic [9:0] W_RAW     = 10'h105;
    localparam logic [9:0] W_MSTAT   = 10'h106;
    localparam logic [9:0] W_ICLR    = 10'h107;
    localparam logic [9:0] W_AFSEL   = 10'h108;
    localparam logic [9:0] W_PAD0    = 10'h140;
    localparam logic [9:0] W_PAD7    = 10'h147;
    localparam logic [9:0] W_LOCK    = 10'h148;
    localparam logic [9:0] W_COMMIT  = 10'h149;
    localparam logic [9:0] W_ANALOG  = 10'h14A;
    localparam logic [9:0] W_RSV_EXT = 10'h14B;
    localparam logic [9:0] W_RSV_BAS = 10'h109;
    localparam logic [9:0] W_RSV_END = 10'h3F3;
    localparam logic [9:0] W_ID0     = 10'h3F4;

    function automatic logic [7:0] id_byte(input logic ext, input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd4:    b = ext ? 8'h47 : 8'h46;
            4'd5:    b = 8'h15;
            4'd6:    b = ext ? 8'h08 : 8'h18;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/gpm_decode.sv
module gpm_decode
    import gpm_pkg::*;
#(
    parameter bit EXTENDED = 1'b1,
    parameter int ADDR_W   = 12,
    parameter int PINS     = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output reg_sel_e          sel,
    output logic              err,
    output logic [PINS-1:0]   mask,
    output logic [2:0]        pad_idx,
    output logic [3:0]        id_idx
);
    localparam logic [9:0] RSV_WORD = EXTENDED ? W_RSV_EXT : W_RSV_BAS;
    localparam int         WORD_W   = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              misaligned;
    reg_sel_e          ext_sel;

    assign word       = addr[ADDR_W-1:2];
    assign misaligned = |addr[1:0];
    assign mask       = addr[PINS+1:2];
    assign pad_idx    = word[2:0];
    assign id_idx     = 4'(word - W_ID0);

    generate
        if (EXTENDED) begin : g_ext
            always_comb begin
                ext_sel = SEL_NONE;
                if (word >= W_PAD0 && word <= W_PAD7) ext_sel = SEL_PAD;
                else if (word == W_LOCK)              ext_sel = SEL_LOCK;
                else if (word == W_COMMIT)            ext_sel = SEL_COMMIT;
                else if (word == W_ANALOG)            ext_sel = SEL_ANALOG;
            end
        end else begin : g_base
            assign ext_sel = SEL_NONE;
        end
    endgenerate

    always_comb begin
        sel = SEL_NONE;
        err = 1'b0;
        if (word < W_DIR) begin
            sel = SEL_DATA;
        end else if (wr && word >= RSV_WORD) begin
            err = 1'b1;
        end else if (!wr && word >= RSV_WORD && word <= W_RSV_END) begin
            err = 1'b1;
        end else if (misaligned) begin
            err = 1'b1;
        end else if (word >= W_ID0) begin
            sel = SEL_ID;
        end else begin
            case (word)
                W_DIR:                    sel = SEL_DIR;
                W_ISENSE:                 sel = SEL_ISENSE;
                W_IBOTH:                  sel = SEL_IBOTH;
                W_IEVENT:                 sel = SEL_IEVENT;
                W_IMASK:                  sel = SEL_IMASK;
                W_RAW, W_MSTAT, W_ICLR:   sel = SEL_RDZERO;
                W_AFSEL:                  sel = SEL_AFSEL;
                default:                  sel = ext_sel;
            endcase
            err = (sel == SEL_NONE);
        end
    end
endmodule

// File: rtl/gpm_lock_fsm.sv
module gpm_lock_fsm
    import gpm_pkg::*;
#(
    parameter int          BUS_W      = 32,
    parameter logic [31:0] UNLOCK_KEY = 32'hC0DE_5A1E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_wr,
    input  logic [BUS_W-1:0] wdata,
    output logic             unlocked
);
    lock_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_SHUT: if (lock_wr && wdata == BUS_W'(UNLOCK_KEY)) state_d = LK_OPEN;   // UNLOCK
            LK_OPEN: if (lock_wr && wdata != BUS_W'(UNLOCK_KEY)) state_d = LK_SHUT;   // RELOCK
        endcase
    end

    always_comb begin
        unique case (state_q)
            LK_SHUT: unlocked = 1'b0;
            LK_OPEN: unlocked = 1'b1;
        endcase
    end
endmodule

// File: rtl/gpm_regfile.sv
module gpm_regfile
    import gpm_pkg::*;
#(
    parameter bit EXTENDED = 1'b1,
    parameter int PINS     = 8,
    parameter int NPAD     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  reg_sel_e        sel,
    input  logic [PINS-1:0] wd,
    input  logic [PINS-1:0] mask,
    input  logic [2:0]      pad_idx,
    input  logic [3:0]      id_idx,
    input  logic            unlocked,
    output logic [PINS-1:0] rd,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe
);
    logic [PINS-1:0] data_q, dir_q, isense_q, iboth_q, ievent_q, imask_q;
    logic [PINS-1:0] afsel_q, commit_q, analog_q;
    logic [PINS-1:0] pad_q [NPAD];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            dir_q    <= '0;
            isense_q <= '0;
            iboth_q  <= '0;
            ievent_q <= '0;
            imask_q  <= '0;
            afsel_q  <= '0;
            commit_q <= '1;
            analog_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DATA:   data_q   <= (data_q & ~mask) | (wd & mask);
                SEL_DIR:    dir_q    <= wd;
                SEL_ISENSE: isense_q <= wd;
                SEL_IBOTH:  iboth_q  <= wd;
                SEL_IEVENT: ievent_q <= wd;
                SEL_IMASK:  imask_q  <= wd;
                SEL_AFSEL:  afsel_q  <= (afsel_q & ~commit_q) | (wd & commit_q);
                SEL_COMMIT: if (EXTENDED && unlocked) commit_q <= wd;
                SEL_ANALOG: analog_q <= wd;
                default:    ;
            endcase
        end
    end

    generate
        for (genvar p = 0; p < NPAD; p++) begin : g_pad
            localparam logic [PINS-1:0] PAD_RST = (p == 0) ? '1 : '0;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pad_q[p] <= PAD_RST;
                else if (wr_en && sel == SEL_PAD && pad_idx == 3'(p))
                    pad_q[p] <= wd;
            end
        end
    endgenerate

    always_comb begin
        case (sel)
            SEL_DATA:   rd = data_q & mask;
            SEL_DIR:    rd = dir_q;
            SEL_ISENSE: rd = isense_q;
            SEL_IBOTH:  rd = iboth_q;
            SEL_IEVENT: rd = ievent_q;
            SEL_IMASK:  rd = imask_q;
            SEL_AFSEL:  rd = afsel_q;
            SEL_PAD:    rd = pad_q[pad_idx];
            SEL_LOCK:   rd = PINS'(!unlocked);
            SEL_COMMIT: rd = commit_q;
            SEL_ANALOG: rd = analog_q;
            SEL_ID:     rd = id_byte(EXTENDED, id_idx);
            default:    rd = '0;
        endcase
    end

    assign pin_out = data_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_maskport.sv
module gpio_maskport
    import gpm_pkg::*;
#(
    parameter bit          EXTENDED   = 1'b1,
    parameter int          ADDR_W     = 12,
    parameter int          BUS_W      = 32,
    parameter int          PINS       = 8,
    parameter logic [31:0] UNLOCK_KEY = 32'hC0DE_5A1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [BUS_W-1:0]  acc_wdata,
    output logic              rsp_valid,
    output logic [BUS_W-1:0]  rsp_rdata,
    output logic              rsp_err,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);
    localparam int NPAD = 8;

    reg_sel_e        sel;
    logic            dec_err;
    logic [PINS-1:0] mask;
    logic [2:0]      pad_idx;
    logic [3:0]      id_idx;
    logic            unlocked;
    logic            wr_en;
    logic [PINS-1:0] rd;

    gpm_decode #(.EXTENDED(EXTENDED), .ADDR_W(ADDR_W), .PINS(PINS)) u_dec (
        .addr(acc_addr), .wr(acc_write), .sel(sel), .err(dec_err),
        .mask(mask), .pad_idx(pad_idx), .id_idx(id_idx)
    );

    assign wr_en = acc_valid && acc_write && !dec_err;

    gpm_lock_fsm #(.BUS_W(BUS_W), .UNLOCK_KEY(UNLOCK_KEY)) u_lock (
        .clk(clk), .rst_n(rst_n),
        .lock_wr(wr_en && sel == SEL_LOCK),
        .wdata(acc_wdata), .unlocked(unlocked)
    );

    gpm_regfile #(.EXTENDED(EXTENDED), .PINS(PINS), .NPAD(NPAD)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel),
        .wd(acc_wdata[PINS-1:0]), .mask(mask), .pad_idx(pad_idx),
        .id_idx(id_idx), .unlocked(unlocked), .rd(rd),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_err   <= acc_valid && dec_err;
            rsp_rdata <= (acc_valid && !acc_write) ? BUS_W'(rd) : '0;
        end
    end
endmodule

// File: rtl/gpio_maskport_chk.sv
module gpio_maskport_chk #(
    parameter bit EXTENDED = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [11:0] acc_addr,
    input logic [31:0] acc_wdata,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_err,
    input logic [7:0]  pin_out,
    input logic [7:0]  pin_oe
);
    localparam logic [11:0] RSV = EXTENDED ? 12'h52C : 12'h424;

    logic unused_ok;
    assign unused_ok = ^acc_wdata;

    // R5: one response per request, one cycle later
    a_r5_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);
    a_r5_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);
    a_r5_err_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    // R2: masked read never shows an unmasked bit
    a_r2_masked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_addr < 12'h400)
        |=> ((rsp_rdata & ~{24'h0, $past(acc_addr[9:2])}) == 32'h0) && !rsp_err);

    // R3: masked write leaves unmasked pins alone
    a_r3_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr < 12'h400)
        |=> ((pin_out ^ $past(pin_out)) & ~$past(acc_addr[9:2])) == 8'h0);

    // R4: only a direction write moves pin_oe
    a_r4_oe_only_by_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_write && acc_addr == 12'h400) |=> $stable(pin_oe));

    // R7: reserved reads give zero with error
    a_r7_reserved_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_addr >= RSV && acc_addr <= 12'hFCC)
        |=> rsp_err && rsp_rdata == 32'h0);

    // R8: writes at/above the reserved start change nothing visible
    a_r8_reserved_write: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr >= RSV)
        |=> rsp_err && $stable(pin_out) && $stable(pin_oe));

    // R1: reset state of pins
    a_r1_reset_pins: assert property (@(posedge clk)
        $past(!rst_n) |-> (pin_out == 8'h0 && pin_oe == 8'h0 && !rsp_valid));
endmodule

bind gpio_maskport gpio_maskport_chk #(.EXTENDED(EXTENDED)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_maskport_tb_top.sv
module gpio_maskport_tb_top;
    localparam logic [31:0] KEY = 32'hC0DE_5A1E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;

    logic        rv_e, re_e, rv_b, re_b;
    logic [31:0] rd_e, rd_b;
    logic [7:0]  po_e, oe_e, po_b, oe_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // captured response of the last access
    logic        cv_e, ce_e, cv_b, ce_b;
    logic [31:0] cd_e, cd_b;

    always #10 clk = ~clk;   // 50 MHz

    gpio_maskport #(.EXTENDED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rv_e),
        .rsp_rdata(rd_e), .rsp_err(re_e), .pin_out(po_e), .pin_oe(oe_e)
    );

    gpio_maskport #(.EXTENDED(1'b0)) dut_base (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rv_b),
        .rsp_rdata(rd_b), .rsp_err(re_b), .pin_out(po_b), .pin_oe(oe_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
        @(posedge clk);
        #2;
        cv_e = rv_e; ce_e = re_e; cd_e = rd_e;
        cv_b = rv_b; ce_b = re_b; cd_b = rd_b;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    function automatic logic [7:0] id_exp(input bit ext, input int i);
        logic [7:0] t [12];
        t = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h47, 8'h15, 8'h08, 8'h00,
              8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (!ext) begin t[4] = 8'h46; t[6] = 8'h18; end
        return t[i];
    endfunction

    task automatic t_reset;
        chk("R1 pin_out", {24'h0, po_e}, 32'h0);
        chk("R1 pin_oe", {24'h0, oe_e}, 32'h0);
        bus(1'b0, 12'h3FC, 0); chk("R1 data", cd_e, 32'h0);
        bus(1'b0, 12'h400, 0); chk("R1 dir", cd_e, 32'h0);
        bus(1'b0, 12'h500, 0); chk("R1 drv2", cd_e, 32'hFF);
        bus(1'b0, 12'h524, 0); chk("R1 commit", cd_e, 32'hFF);
        bus(1'b0, 12'h520, 0); chk("R1 lock", cd_e, 32'h1);
        bus(1'b0, 12'h504, 0); chk("R1 drv4", cd_e, 32'h0);
        bus(1'b0, 12'h528, 0); chk("R1 analog", cd_e, 32'h0);
    endtask

    task automatic t_masked_data;
        bus(1'b1, 12'h3FC, 32'hFFFF_FFA5);
        chk("R3 full write pin_out", {24'h0, po_e}, 32'hA5);
        bus(1'b0, 12'h3FC, 0); chk("R2 full read", cd_e, 32'hA5);
        bus(1'b0, 12'h03C, 0); chk("R2 low nibble read", cd_e, 32'h05);
        chk("R2 no err", {31'h0, ce_e}, 32'h0);
        bus(1'b1, 12'h3C0, 32'h0F); chk("R3 upper clear", {24'h0, po_e}, 32'h05);
        bus(1'b1, 12'h004, 32'hFF); chk("R3 bit0 only", {24'h0, po_e}, 32'h05);
        bus(1'b1, 12'h008, 32'hFF); chk("R3 bit1 only", {24'h0, po_e}, 32'h07);
        bus(1'b0, 12'h000, 0); chk("R2 empty mask", cd_e, 32'h0);
        bus(1'b0, 12'h018, 0); chk("R2 mask 06", cd_e, 32'h06);
    endtask

    task automatic t_dir;
        bus(1'b1, 12'h400, 32'h1234_56C3);
        chk("R4 pin_oe", {24'h0, oe_e}, 32'hC3);
        bus(1'b0, 12'h400, 0); chk("R4 dir truncated", cd_e, 32'hC3);
        bus(1'b1, 12'h404, 32'h77);
        chk("R4 pin_oe untouched", {24'h0, oe_e}, 32'hC3);
    endtask

    task automatic t_timing;
        bus(1'b0, 12'h4F0, 0);
        chk("R5 valid", {31'h0, cv_e}, 32'h1);
        chk("R5 err", {31'h0, ce_e}, 32'h1);
        @(posedge clk); #2;
        chk("R5 valid drops", {31'h0, rv_e}, 32'h0);
        chk("R5 err one cycle", {31'h0, re_e}, 32'h0);
    endtask

    task automatic t_id;
        for (int i = 0; i < 12; i++) begin
            bus(1'b0, 12'hFD0 + 12'(4 * i), 0);
            chk("R6 id ext", cd_e, {24'h0, id_exp(1'b1, i)});
            chk("R6 id base", cd_b, {24'h0, id_exp(1'b0, i)});
        end
        bus(1'b1, 12'hFE0, 32'h55);
        chk("R8 id write err", {31'h0, ce_e}, 32'h1);
        bus(1'b0, 12'hFE0, 0);
        chk("R8 id unchanged", cd_e, {24'h0, id_exp(1'b1, 4)});
    endtask

    task automatic t_reserved;
        bus(1'b0, 12'h424, 0);
        chk("R7 base start err", {31'h0, ce_b}, 32'h1);
        chk("R7 base start data", cd_b, 32'h0);
        bus(1'b1, 12'h528, 32'h3C);
        chk("R8 base analog write err", {31'h0, ce_b}, 32'h1);
        chk("R7 ext analog write ok", {31'h0, ce_e}, 32'h0);
        bus(1'b0, 12'h528, 0);
        chk("R7 ext analog read", cd_e, 32'h3C);
        chk("R7 base analog read zero", cd_b, 32'h0);
        bus(1'b0, 12'h52C, 0);
        chk("R7 ext start err", {31'h0, ce_e}, 32'h1);
        bus(1'b0, 12'hFCC, 0);
        chk("R7 end err", {31'h0, ce_e}, 32'h1);
        bus(1'b1, 12'h500, 32'h00);
        chk("R8 base pad write err", {31'h0, ce_b}, 32'h1);
        bus(1'b1, 12'h52C, 32'h00);
        chk("R8 ext write err", {31'h0, ce_e}, 32'h1);
    endtask

    task automatic t_unlisted;
        bus(1'b1, 12'h4F0, 32'hFF);
        chk("R9 unlisted write err", {31'h0, ce_e}, 32'h1);
        bus(1'b1, 12'h402, 32'h00);
        chk("R9 misaligned err", {31'h0, ce_e}, 32'h1);
        bus(1'b0, 12'h400, 0);
        chk("R9 dir kept", cd_e, 32'hC3);
    endtask

    task automatic t_irq;
        bus(1'b1, 12'h408, 32'h5A); bus(1'b0, 12'h408, 0);
        chk("R13 both-edges", cd_e, 32'h5A);
        bus(1'b1, 12'h410, 32'h81); bus(1'b0, 12'h410, 0);
        chk("R13 mask", cd_e, 32'h81);
        bus(1'b1, 12'h41C, 32'hFF);
        chk("R13 clear no err", {31'h0, ce_e}, 32'h0);
        bus(1'b0, 12'h414, 0); chk("R13 raw zero", cd_e, 32'h0);
        bus(1'b0, 12'h418, 0); chk("R13 masked zero", cd_e, 32'h0);
    endtask

    task automatic t_lock_commit;
        bus(1'b1, 12'h524, 32'h00);
        chk("R11 locked commit no err", {31'h0, ce_e}, 32'h0);
        bus(1'b0, 12'h524, 0); chk("R11 locked commit kept", cd_e, 32'hFF);
        bus(1'b1, 12'h520, KEY);
        bus(1'b0, 12'h520, 0); chk("R10 unlocked", cd_e, 32'h0);
        bus(1'b1, 12'h524, 32'h0F);
        bus(1'b0, 12'h524, 0); chk("R11 commit written", cd_e, 32'h0F);
        bus(1'b1, 12'h520, KEY ^ 32'h0100_0000);
        bus(1'b0, 12'h520, 0); chk("R10 relocked", cd_e, 32'h1);
        bus(1'b1, 12'h524, 32'h00);
        bus(1'b0, 12'h524, 0); chk("R11 ignored after relock", cd_e, 32'h0F);
    endtask

    task automatic t_afsel;
        bus(1'b1, 12'h420, 32'hFF);
        bus(1'b0, 12'h420, 0);
        chk("R12 afsel gated ext", cd_e, 32'h0F);
        chk("R12 afsel base full", cd_b, 32'hFF);
        bus(1'b1, 12'h420, 32'h00);
        bus(1'b0, 12'h420, 0);
        chk("R12 afsel cleared", cd_e, 32'h00);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_masked_data();
        t_dir();
        t_timing();
        t_id();
        t_reserved();
        t_unlisted();
        t_irq();
        t_lock_commit();
        t_afsel();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule